// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Emulator

This block is a clock-sampled, synthesizable stand-in for a byte-wide nonvolatile memory that is driven like a static RAM. Three active-low strobes (chip select, output enable, write strobe) are sampled on the system clock. A read puts the addressed byte on a split data bus whose drive-enable output tells the pad when to drive. A write latches one address and one byte. The block then goes busy for a self-timed cycle: it first erases the location to all ones and then programs it.

While the cycle runs, the block reports status in two ways. It holds an open-drain busy pull-down, which several devices can share on one wire. It also answers every read with a polling word that carries the inverted top bit of the byte being written. Writes are blocked in four cases:
- output enable is low;
- either strobe is idle;
- the supply-good input has not been high for a power-up delay;
- a cycle is already running.

An identification-enable input redirects the top 32 addresses to a separate 32-byte store. At a 13-bit address width these are 0x1FE0 to 0x1FFF. A clear-enable input, combined with a long held write strobe, sets the whole main array to 0xFF.

The controller is a state machine with six states:
- **LOCK**: waiting out the power-up delay.
- **IDLE**: ready for an access.
- **ERASE**: one cycle that writes all ones to the latched location.
- **PROG**: the rest of the write time, ending with the byte being stored.
- **CLEAR**: timing a held clear strobe.
- **CLDONE**: waiting for the strobe to be released after a clear.

The transitions are:
- Any state goes to LOCK when supply-good is sampled low.
- LOCK goes to IDLE when the delay has elapsed.
- IDLE goes to CLEAR when a clear strobe is seen.
- IDLE goes to ERASE when a write is accepted.
- ERASE always goes to PROG.
- PROG goes to IDLE when the count ends.
- CLEAR goes back to IDLE if the strobe is released early.
- CLEAR goes to CLDONE when the hold time is reached.
- CLDONE goes to IDLE on release.

Top module: `selftimed_bytemem`

## Requirements
- R1: With chip select and output enable low and the write strobe high in a clock sample, `dq_oe` is 1 and `dout` shows the addressed byte after that same clock edge. In any sample with chip select or output enable high, `dq_oe` is 0 and `dout` is zero.
- R2: A write is the interval of samples in which chip select and write strobe are both low. Its address is taken from the first sample of that interval, which is the edge of whichever strobe fell last. Its data is taken from the last sample of that interval, just before whichever strobe rose first.
- R3: An accepted write sets `rdy_pulldown` to 1 from the second clock edge after the first sample with a strobe high, for exactly the write-cycle count of clock cycles. After that the byte is stored and can be read back.
- R4: While `rdy_pulldown` is 1, every read at any address returns bit 7 equal to the inverse of bit 7 of the byte being written, and bits 6 to 0 equal to zero. Once it drops, reads return true stored data.
- R5: No write starts if output enable is low in the last both-low sample, or if only one strobe goes low. `rdy_pulldown` stays 0 and the contents are unchanged.
- R6: Strobe pulses that begin while a write cycle runs are ignored. They neither store data nor lengthen the busy time.
- R7: After reset, writes are ignored until `pwr_good` has been sampled high for the power-up count of cycles. Reads work during this time.
- R8: Sampling `pwr_good` low returns the block to LOCK and restarts the power-up delay.
- R9: With `id_en` high, an address whose upper bits are all ones selects the 32-byte ID store for both reads and writes, indexed by the low five bits. The main array at those addresses is untouched and reappears when `id_en` is low. Other addresses still reach the main array.
- R10: With `clr_en` high, chip select low and write strobe low for at least the clear count plus one samples, every main-array byte becomes 0xFF. The ID store keeps its contents. A shorter hold changes nothing, and the pulse never starts a byte write.
- R11: With the fast option selected, the busy time is the fast write-cycle count instead of the standard one.
- R12: After reset, `rdy_pulldown` is 0, the controller is in LOCK and every byte of both stores reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data from the bus |
| dout | output | DATA_W | Data toward the bus (zero when not driving) |
| dq_oe | output | 1 | Bus drive enable for the pad |
| rdy_pulldown | output | 1 | 1 pulls the shared open-drain ready/busy line low |
| pwr_good | input | 1 | Supply-good indication |
| id_en | input | 1 | Maps the top 32 addresses to the ID store |
| clr_en | input | 1 | Turns a held write strobe into a whole-array clear |

## Verification
Read results appear one clock edge after the sample that presents the address, so the bench changes inputs on falling edges and compares at the next falling edge. The busy pull-down first shows two edges after the first sample with a strobe high. The bench therefore checks that it is still 0 at the first falling edge after release, then counts the falling edges on which it is 1 and expects exactly the write-cycle count. It compares the polling word on each of those edges and compares true data on the first edge after the line drops. Lockout and clear results follow sample counts: a clear needs count-plus-one low samples, and a write is accepted only once the power-up count has run. The bench places its pulses well inside or well outside those windows and checks the effect with reads afterwards.

// File: rtl/stbm_pkg.sv
package stbm_pkg;
    typedef enum logic [2:0] {
        ST_LOCK,
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_CLEAR,
        ST_CLDONE
    } stbm_state_e;
endpackage

// File: rtl/stbm_sampler.sv
module stbm_sampler #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int ID_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              pwr_good,
    input  logic              id_en,
    input  logic              clr_en,
    output logic              s_ce_n,
    output logic              s_oe_n,
    output logic              s_we_n,
    output logic [ADDR_W-1:0] s_addr,
    output logic              s_pg,
    output logic              s_clr,
    output logic              s_idsel,
    output logic              p_oe_n,
    output logic              p_clr,
    output logic [DATA_W-1:0] p_din,
    output logic              wr_rise,
    output logic              wr_fall
);
    localparam int ID_W = $clog2(ID_BYTES);

    logic              s_id;
    logic [DATA_W-1:0] s_din;
    logic              p_ce_n, p_we_n;
    logic              act_now, act_prev;

    // one sample stage plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_ce_n <= 1'b1;  s_oe_n <= 1'b1;  s_we_n <= 1'b1;
            s_addr <= '0;    s_din  <= '0;    s_pg   <= 1'b0;
            s_id   <= 1'b0;  s_clr  <= 1'b0;
            p_ce_n <= 1'b1;  p_we_n <= 1'b1;  p_oe_n <= 1'b1;
            p_clr  <= 1'b0;  p_din  <= '0;
        end else begin
            p_ce_n <= s_ce_n;  p_we_n <= s_we_n;  p_oe_n <= s_oe_n;
            p_clr  <= s_clr;   p_din  <= s_din;
            s_ce_n <= ce_n;    s_oe_n <= oe_n;    s_we_n <= we_n;
            s_addr <= addr;    s_din  <= din;     s_pg   <= pwr_good;
            s_id   <= id_en;   s_clr  <= clr_en;
        end
    end

    assign act_now  = ~s_ce_n & ~s_we_n;
    assign act_prev = ~p_ce_n & ~p_we_n;
    assign wr_rise  = act_now & ~act_prev;
    assign wr_fall  = ~act_now & act_prev;
    assign s_idsel  = s_id & (&s_addr[ADDR_W-1:ID_W]);
endmodule

// File: rtl/stbm_ctrl.sv
module stbm_ctrl
    import stbm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int WCYC   = 50000,
    parameter int PCYC   = 250000,
    parameter int CCYC   = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_pg,
    input  logic              s_ce_n,
    input  logic              s_we_n,
    input  logic              s_clr,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_idsel,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              p_oe_n,
    input  logic              p_clr,
    input  logic [DATA_W-1:0] p_din,
    output logic              busy,
    output logic              lat_msb,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_id,
    output logic [DATA_W-1:0] wr_data,
    output logic              clr_all
);
    localparam int MAX_PC = (PCYC > CCYC) ? PCYC : CCYC;
    localparam int MAXC   = (MAX_PC > WCYC) ? MAX_PC : WCYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PROG_END  = CNT_W'(WCYC - 2);
    localparam logic [CNT_W-1:0] LOCK_END  = CNT_W'(PCYC - 1);
    localparam logic [CNT_W-1:0] CLEAR_END = CNT_W'(CCYC - 1);

    stbm_state_e       state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_id, lat_valid;
    logic [DATA_W-1:0] lat_data;
    logic              clr_act, accept;

    assign clr_act = s_clr & ~s_ce_n & ~s_we_n;
    assign accept  = wr_fall & lat_valid & p_oe_n & ~p_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCK;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!s_pg) begin
            nxt = ST_LOCK;
        end else begin
            unique case (state)
                ST_LOCK:   if (cnt == LOCK_END) nxt = ST_IDLE;
                ST_IDLE:   if (clr_act) nxt = ST_CLEAR;
                           else if (accept) nxt = ST_ERASE;
                ST_ERASE:  nxt = ST_PROG;
                ST_PROG:   if (cnt == PROG_END) nxt = ST_IDLE;
                ST_CLEAR:  if (!clr_act) nxt = ST_IDLE;
                           else if (cnt == CLEAR_END) nxt = ST_CLDONE;
                ST_CLDONE: if (!clr_act) nxt = ST_IDLE;
                default:   nxt = ST_LOCK;
            endcase
        end
    end

    // timer and write latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; lat_addr <= '0; lat_id <= 1'b0;
            lat_valid <= 1'b0; lat_data <= '0;
        end else begin
            if (!s_pg || nxt != state)
                cnt <= '0;
            else if (state == ST_LOCK || state == ST_PROG || state == ST_CLEAR)
                cnt <= cnt + 1'b1;

            if (!s_pg || wr_fall) begin
                lat_valid <= 1'b0;
            end else if (wr_rise && state == ST_IDLE) begin
                lat_valid <= 1'b1;
                lat_addr  <= s_addr;
                lat_id    <= s_idsel;
            end

            if (state == ST_IDLE && nxt == ST_ERASE)
                lat_data <= p_din;
        end
    end

    // outputs
    always_comb begin
        busy    = (state == ST_ERASE) || (state == ST_PROG);
        lat_msb = lat_data[DATA_W-1];
        wr_addr = lat_addr;
        wr_id   = lat_id;
        wr_en   = s_pg && ((state == ST_ERASE) ||
                           (state == ST_PROG && cnt == PROG_END));
        wr_data = (state == ST_ERASE) ? '1 : lat_data;
        clr_all = s_pg && clr_act && (state == ST_CLEAR) && (cnt == CLEAR_END);
    end

    // busy only ever begins right after a sampled strobe release
    p_busy_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_fall));

    // programming count never runs past its end value
    p_prog_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> (cnt <= PROG_END));

    // no write cycle can begin straight out of the lockout
    p_locked_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |=> !busy);

    // the byte being programmed cannot be replaced mid-cycle
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_data));
endmodule

// File: rtl/stbm_store.sv
module stbm_store #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int ID_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_id,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int ID_W  = $clog2(ID_BYTES);

    logic [DATA_W-1:0] main_q [DEPTH];
    logic [DATA_W-1:0] id_q   [ID_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)    main_q[i] <= '1;
            for (int j = 0; j < ID_BYTES; j++) id_q[j]   <= '1;
        end else if (clr_all) begin
            for (int i = 0; i < DEPTH; i++)    main_q[i] <= '1;
        end else if (wr_en) begin
            if (wr_id) id_q[wr_addr[ID_W-1:0]] <= wr_data;
            else       main_q[wr_addr]         <= wr_data;
        end
    end

    assign rd_data = rd_id ? id_q[rd_addr[ID_W-1:0]] : main_q[rd_addr];

    // a clear and a byte write never land in the same cycle
    p_clear_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_all && wr_en));
endmodule

// File: rtl/selftimed_bytemem.sv
module selftimed_bytemem #(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter int ID_BYTES       = 32,
    parameter bit FAST           = 1'b0,
    parameter int WRITE_CYCLES   = 50000,
    parameter int FAST_CYCLES    = 10000,
    parameter int POWERUP_CYCLES = 250000,
    parameter int CLEAR_CYCLES   = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe,
    output logic              rdy_pulldown,
    input  logic              pwr_good,
    input  logic              id_en,
    input  logic              clr_en
);
    localparam int WCYC = FAST ? FAST_CYCLES : WRITE_CYCLES;

    logic              s_ce_n, s_oe_n, s_we_n, s_pg, s_clr, s_idsel;
    logic [ADDR_W-1:0] s_addr;
    logic              p_oe_n, p_clr, wr_rise, wr_fall;
    logic [DATA_W-1:0] p_din;
    logic              busy, lat_msb, wr_en, wr_id, clr_all;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    stbm_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES)) u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .pwr_good(pwr_good), .id_en(id_en), .clr_en(clr_en),
        .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n), .s_addr(s_addr),
        .s_pg(s_pg), .s_clr(s_clr), .s_idsel(s_idsel), .p_oe_n(p_oe_n),
        .p_clr(p_clr), .p_din(p_din), .wr_rise(wr_rise), .wr_fall(wr_fall));

    stbm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WCYC(WCYC),
                .PCYC(POWERUP_CYCLES), .CCYC(CLEAR_CYCLES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .s_pg(s_pg), .s_ce_n(s_ce_n), .s_we_n(s_we_n),
        .s_clr(s_clr), .s_addr(s_addr), .s_idsel(s_idsel), .wr_rise(wr_rise),
        .wr_fall(wr_fall), .p_oe_n(p_oe_n), .p_clr(p_clr), .p_din(p_din),
        .busy(busy), .lat_msb(lat_msb), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_id(wr_id), .wr_data(wr_data), .clr_all(clr_all));

    stbm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_id(wr_id),
        .wr_data(wr_data), .clr_all(clr_all), .rd_addr(s_addr), .rd_id(s_idsel),
        .rd_data(rd_data));

    assign dq_oe        = ~s_ce_n & ~s_oe_n & s_we_n;
    assign rdy_pulldown = busy;

    always_comb begin
        if (!dq_oe)    dout = '0;
        else if (busy) dout = {~lat_msb, {(DATA_W-1){1'b0}}};
        else           dout = rd_data;
    end

    // polling word keeps its low bits at zero
    p_poll_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dout[DATA_W-2:0] == '0));
endmodule

// File: tb/sim_selftimed_bytemem.sv
module sim_selftimed_bytemem;
    localparam int AW = 7;
    localparam int W  = 12;
    localparam int FW = 4;
    localparam int P  = 20;
    localparam int C  = 30;
    localparam int IDB = 32;
    localparam int IDBASE = (1 << AW) - IDB;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, we_n, pg, idn, clr;
    logic [AW-1:0] addr;
    logic [7:0] din, dout0, dout1;
    logic oe0, oe1, rdy0, rdy1;
    logic [7:0] em [1 << AW];
    logic [7:0] eid [IDB];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    selftimed_bytemem #(.ADDR_W(AW), .DATA_W(8), .ID_BYTES(IDB), .FAST(1'b0),
        .WRITE_CYCLES(W), .FAST_CYCLES(FW), .POWERUP_CYCLES(P), .CLEAR_CYCLES(C)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .din(din), .dout(dout0), .dq_oe(oe0), .rdy_pulldown(rdy0), .pwr_good(pg),
        .id_en(idn), .clr_en(clr));

    selftimed_bytemem #(.ADDR_W(AW), .DATA_W(8), .ID_BYTES(IDB), .FAST(1'b1),
        .WRITE_CYCLES(W), .FAST_CYCLES(FW), .POWERUP_CYCLES(P), .CLEAR_CYCLES(C)) u1 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .din(din), .dout(dout1), .dq_oe(oe1), .rdy_pulldown(rdy1), .pwr_good(pg),
        .id_en(idn), .clr_en(clr));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input int a, input logic idf);
        if (idf && a >= IDBASE) return eid[a - IDBASE];
        return em[a];
    endfunction

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic read_chk(input int a, input logic idf, input string tag);
        @(negedge clk);
        addr = AW'(a); idn = idf; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        check({tag, " drive"}, {31'd0, oe0}, 32'd1);
        check({tag, " data"}, {24'd0, dout0}, {24'd0, model(a, idf)});
        bus_idle();
    endtask

    // accepted write: busy length, polling word, true data after
    task automatic write_measure(input int a, input logic [7:0] d, input logic idf, input int pa);
        int cnt, cnt1;
        logic done;
        @(negedge clk);
        addr = AW'(a); din = d; idn = idf; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        check("R3 not busy one edge after release", {31'd0, rdy0}, 32'd0);
        addr = AW'(pa); ce_n = 1'b0; oe_n = 1'b0;
        if (idf && a >= IDBASE) eid[a - IDBASE] = d; else em[a] = d;
        cnt = 0; cnt1 = 0; done = 1'b0;
        for (int i = 0; i < W + 8 && !done; i++) begin
            @(negedge clk);
            if (rdy1) cnt1++;
            if (rdy0) begin
                cnt++;
                check("R4 polling word", {24'd0, dout0}, {24'd0, ~d[7], 7'd0});
            end else if (cnt > 0) begin
                done = 1'b1;
            end
        end
        check("R3 busy cycles", cnt, W);
        check("R11 fast busy cycles", cnt1, FW);
        check("R4 true data after busy", {24'd0, dout0}, {24'd0, model(pa, idf)});
        bus_idle();
    endtask

    // pulse that must not start a write
    task automatic write_reject(input int a, input logic [7:0] d, input logic cv,
                                input logic wv, input logic ov, input string tag);
        logic seen;
        @(negedge clk);
        addr = AW'(a); din = d; idn = 1'b0; ce_n = cv; we_n = wv; oe_n = ov;
        @(negedge clk); @(negedge clk);
        bus_idle();
        seen = 1'b0;
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            if (rdy0) seen = 1'b1;
        end
        check({tag, " no busy"}, {31'd0, seen}, 32'd0);
        read_chk(a, 1'b0, {tag, " contents kept"});
    endtask

    task automatic clear_pulse(input int hold);
        @(negedge clk);
        clr = 1'b1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; idn = 1'b0;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic seen;
        int cnt;
        for (int i = 0; i < (1 << AW); i++) em[i] = 8'hFF;
        for (int i = 0; i < IDB; i++) eid[i] = 8'hFF;
        rst_n = 1'b0; pg = 1'b0; idn = 1'b0; clr = 1'b0;
        addr = '0; din = '0; bus_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset no busy", {31'd0, rdy0}, 32'd0);
        check("R1 idle bus not driven", {31'd0, oe0}, 32'd0);
        read_chk(3, 1'b0, "R12 main erased");
        read_chk(IDBASE + 4, 1'b1, "R12 id erased");

        // R7: lockout after supply good
        @(negedge clk); pg = 1'b1;
        write_reject(5, 8'h12, 1'b0, 1'b0, 1'b1, "R7 early write");
        repeat (P + 5) @(negedge clk);

        // R2 R3 R4 R11: sweep every main address
        for (int a = 0; a < (1 << AW); a++)
            write_measure(a, 8'((a * 37 + 11) & 8'hFF), 1'b0, a ^ 8'h2A);
        for (int a = 0; a < (1 << AW); a++)
            read_chk(a, 1'b0, "R1 sweep readback");

        // R1 high impedance
        @(negedge clk); addr = 7'd9; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk); check("R1 oe high not driven", {24'd0, oe0, dout0}, 32'd0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); check("R1 ce high not driven", {24'd0, oe0, dout0}, 32'd0);
        bus_idle();

        // R2: chip-select controlled, address moves and data changes inside the pulse
        @(negedge clk); addr = 7'd10; din = 8'h3C; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); addr = 7'd11;
        @(negedge clk); din = 8'h5A;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        repeat (W + 6) @(negedge clk);
        em[10] = 8'h5A;
        read_chk(10, 1'b0, "R2 first-sample address last-sample data");
        read_chk(11, 1'b0, "R2 moved address untouched");

        // R5: inhibited pulses
        write_reject(20, 8'h00, 1'b0, 1'b0, 1'b0, "R5 output enable low");
        write_reject(21, 8'h00, 1'b1, 1'b0, 1'b1, "R5 chip select idle");

        // R6: pulse during busy is ignored
        @(negedge clk); addr = 7'd30; din = 8'h81; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); @(negedge clk); bus_idle();
        cnt = 0;
        for (int i = 0; i < W + 12; i++) begin
            @(negedge clk);
            if (rdy0) cnt++;
            if (i == 2) begin addr = 7'd31; din = 8'h07; ce_n = 1'b0; we_n = 1'b0; end
            if (i == 4) bus_idle();
        end
        em[30] = 8'h81;
        check("R6 busy not lengthened", cnt, W);
        read_chk(30, 1'b0, "R6 first write stored");
        read_chk(31, 1'b0, "R6 busy-time write ignored");

        // R8: supply drop relocks
        @(negedge clk); pg = 1'b0;
        @(negedge clk); @(negedge clk); pg = 1'b1;
        write_reject(40, 8'h99, 1'b0, 1'b0, 1'b1, "R8 relocked write");
        repeat (P + 5) @(negedge clk);
        write_measure(40, 8'h99, 1'b0, 40);

        // R9: identification store
        for (int i = 0; i < IDB; i++)
            write_measure(IDBASE + i, 8'hC3 ^ 8'(i * 5), 1'b1, IDBASE + i);
        write_measure(IDBASE - 1, 8'h6E, 1'b1, IDBASE - 1);
        for (int i = 0; i < IDB; i++) begin
            read_chk(IDBASE + i, 1'b1, "R9 id view");
            read_chk(IDBASE + i, 1'b0, "R9 main view kept");
        end
        read_chk(IDBASE - 1, 1'b0, "R9 below window is main");

        // R10: short hold does nothing, long hold clears main only
        clear_pulse(C - 3);
        read_chk(0, 1'b0, "R10 short hold keeps");
        read_chk(77, 1'b0, "R10 short hold keeps");
        clear_pulse(C + 5);
        seen = rdy0;
        check("R10 clear pulse no byte write", {31'd0, seen}, 32'd0);
        for (int a = 0; a < (1 << AW); a++) em[a] = 8'hFF;
        for (int a = 0; a < (1 << AW); a++) read_chk(a, 1'b0, "R10 main cleared");
        for (int i = 0; i < IDB; i++) read_chk(IDBASE + i, 1'b1, "R10 id kept");

        summary();
        $finish;
    end
endmodule